// File: doc/BRIEF.md
# Bandwidth-Weighted Polling Scheduler

This block is the polling engine of a shared-bus controller. At each timeslot strobe it walks a table of device numbers, skipping entries that are unused or that belong to devices marked as failed. It then publishes the number of the device that owns the upstream direction in the following slot. A device's share of the bus is set by how many table entries carry its number. Software edits the table through a simple write port.

The block also watches for devices that have gone silent. Every completed pass over the table ages each device that appears in it. When a device has stayed silent for a set number of passes, the block raises a one-cycle request asking the controller to send that device a diagnostic frame. A device that leaves several diagnostics unanswered is flagged as failed, and its entries are passed over until it sends a frame again. A frame from a device, or an answer to a diagnostic, resets that device's history.

Top module: `poll_sched`

## Requirements
- R1: While reset is held and immediately after it, `mux_o` is 0xFF, and `diag_o` and `failed_o` are all zero. Every table entry is invalid, and the scan position is entry 0.
- R2: A slot strobe is sampled on a rising edge. One cycle later, `mux_o` holds the device number of the first eligible entry at or after the scan position, searching upward in index order and wrapping from the last entry to entry 0. The device number is zero-extended to 8 bits. The scan position then moves to the entry after the chosen one. `mux_o` changes only after a slot strobe, so a device listed k times is granted k times per pass.
- R3: An entry is eligible only if its valid bit is set and the device it names is not flagged in `failed_o`. Ineligible entries are passed over within the same slot and cost no extra slot.
- R4: If no entry is eligible, the slot yields 0xFF on `mux_o` and the scan position does not move.
- R5: A write (`wr_en_i` with index, device, valid) is seen by every slot strobe after the write cycle. A strobe in the same cycle as the write still uses the entry's old content.
- R6: A pass completes on a slot whose new scan position is less than or equal to the old one, or on a slot with no eligible entry. Each completed pass advances the age of every listed, non-failed device. On the 16th pass without traffic, the age restarts and the device's bit in `diag_o` is high for exactly one cycle, one cycle after that strobe.
- R7: A frame event (`frame_vld_i`, `frame_dev_i`) clears that device's age, its count of unanswered diagnostics and its failed flag. Its `failed_o` bit is low from the next cycle.
- R8: A diagnostic answer (`ans_vld_i`, `ans_dev_i`) clears that device's age and its count of unanswered diagnostics.
- R9: Consider a device whose age expires after three diagnostics have already gone unanswered. Instead of a fourth diagnostic, its `failed_o` bit is set one cycle after that strobe. A failed device is not aged and receives no further diagnostics.
- R10: A device that has no valid table entry is neither aged nor sent diagnostics. Removing its last entry freezes its age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_i | input | 1 | Timeslot strobe, one cycle per slot |
| frame_vld_i | input | 1 | A frame has arrived from a device |
| frame_dev_i | input | 5 | Number of the device that sent the frame |
| ans_vld_i | input | 1 | A diagnostic answer has arrived |
| ans_dev_i | input | 5 | Number of the device that answered |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 6 | Table entry to write |
| wr_dev_i | input | 5 | Device number to store |
| wr_valid_i | input | 1 | Valid bit to store (0 removes the entry) |
| mux_o | output | 8 | Device granted the next slot, or 0xFF when idle |
| diag_o | output | 32 | One-cycle pulse per device needing a diagnostic frame |
| failed_o | output | 32 | Devices currently flagged as failed |

## Verification
Every result of a slot strobe is registered once: `mux_o`, the `diag_o` pulse and any new `failed_o` bit all appear in the cycle after the edge that sampled the strobe. Frame and answer events take effect at the next edge. The bench raises each stimulus on a falling edge, drops it on the next falling edge and compares all three outputs at that same instant. This lands exactly one edge after the sampling edge, which is the only cycle in which a diagnostic pulse is visible. A reference model written from the requirements holds the table, the scan position and the per-device counters. It is stepped at the strobe, so every slot of long silent stretches is compared, including the slot in which a device fails and the idle slots that follow.

// File: rtl/poll_pkg.sv
package poll_pkg;

   typedef enum logic [1:0] {
      HL_QUIET = 2'd0,
      HL_DIAG  = 2'd1,
      HL_FAIL  = 2'd2
   } health_evt_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/poll_table.sv
module poll_table #(
   parameter int unsigned TBL_DEPTH = 64,
   parameter int unsigned N_DEV     = 32,
   parameter int unsigned DEV_W     = 5,
   parameter int unsigned IDX_W     = 6
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       wr_en_i,
   input  logic [IDX_W-1:0]           wr_idx_i,
   input  logic [DEV_W-1:0]           wr_dev_i,
   input  logic                       wr_valid_i,
   output logic [TBL_DEPTH-1:0]       vld_o,
   output logic [TBL_DEPTH*DEV_W-1:0] dev_o,
   output logic [N_DEV-1:0]           present_o
);

   logic [TBL_DEPTH-1:0] vld_q;
   logic [DEV_W-1:0]     dev_q [TBL_DEPTH];

   for (genvar e = 0; e < TBL_DEPTH; e++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            vld_q[e] <= 1'b0;
            dev_q[e] <= '0;
         end else if (wr_en_i && (wr_idx_i == IDX_W'(e))) begin
            vld_q[e] <= wr_valid_i;
            dev_q[e] <= wr_dev_i;
         end
      end
      assign dev_o[e*DEV_W +: DEV_W] = dev_q[e];
   end

   assign vld_o = vld_q;

   always_comb begin
      present_o = '0;
      for (int e = 0; e < TBL_DEPTH; e++) begin
         if (vld_q[e]) present_o[dev_q[e]] = 1'b1;
      end
   end

endmodule

// File: rtl/poll_pick.sv
module poll_pick #(
   parameter int unsigned TBL_DEPTH = 64,
   parameter int unsigned N_DEV     = 32,
   parameter int unsigned DEV_W     = 5,
   parameter int unsigned IDX_W     = 6
) (
   input  logic [TBL_DEPTH-1:0]       vld_i,
   input  logic [TBL_DEPTH*DEV_W-1:0] dev_i,
   input  logic [N_DEV-1:0]           failed_i,
   input  logic [IDX_W-1:0]           ptr_i,
   output logic                       found_o,
   output logic [DEV_W-1:0]           dev_o,
   output logic [IDX_W-1:0]           nxt_ptr_o,
   output logic                       wrap_o
);

   logic [TBL_DEPTH-1:0] elig;
   logic [IDX_W-1:0]     hit_idx;
   logic [IDX_W-1:0]     cand;

   for (genvar e = 0; e < TBL_DEPTH; e++) begin : g_elig
      assign elig[e] = vld_i[e] && !failed_i[dev_i[e*DEV_W +: DEV_W]];
   end

   always_comb begin
      found_o = 1'b0;
      hit_idx = '0;
      cand    = '0;
      for (int k = 0; k < TBL_DEPTH; k++) begin
         cand = ptr_i + IDX_W'(k);
         if (!found_o && elig[cand]) begin
            found_o = 1'b1;
            hit_idx = cand;
         end
      end
   end

   assign dev_o     = dev_i[hit_idx*DEV_W +: DEV_W];
   assign nxt_ptr_o = found_o ? (hit_idx + IDX_W'(1)) : ptr_i;
   assign wrap_o    = !found_o || (nxt_ptr_o <= ptr_i);

endmodule

// File: rtl/poll_health.sv
module poll_health
   import poll_pkg::*;
#(
   parameter int unsigned N_DEV     = 32,
   parameter int unsigned DEV_W     = 5,
   parameter int unsigned AGE_SCANS = 16,
   parameter int unsigned MISS_MAX  = 3,
   parameter int unsigned AGE_W     = 4,
   parameter int unsigned MISS_W    = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             scan_i,
   input  logic [N_DEV-1:0] present_i,
   input  logic             frame_vld_i,
   input  logic [DEV_W-1:0] frame_dev_i,
   input  logic             ans_vld_i,
   input  logic [DEV_W-1:0] ans_dev_i,
   output logic [N_DEV-1:0] diag_o,
   output logic [N_DEV-1:0] failed_o
);

   localparam logic [AGE_W-1:0]  AGE_TOP  = AGE_W'(AGE_SCANS - 1);
   localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(MISS_MAX);

   for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      logic [AGE_W-1:0]  age_q;
      logic [MISS_W-1:0] miss_q;
      logic              fail_q;
      logic              diag_q;
      logic              hit_frame;
      logic              hit_ans;
      logic              ages;
      health_evt_e       evt;

      assign hit_frame = frame_vld_i && (frame_dev_i == DEV_W'(d));
      assign hit_ans   = ans_vld_i && (ans_dev_i == DEV_W'(d));
      assign ages      = scan_i && present_i[d] && !fail_q;

      always_comb begin
         evt = HL_QUIET;
         if (ages && (age_q == AGE_TOP)) evt = (miss_q < MISS_TOP) ? HL_DIAG : HL_FAIL;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            age_q  <= '0;
            miss_q <= '0;
            fail_q <= 1'b0;
            diag_q <= 1'b0;
         end else begin
            diag_q <= 1'b0;
            if (hit_frame) begin
               age_q  <= '0;
               miss_q <= '0;
               fail_q <= 1'b0;
            end else if (hit_ans) begin
               age_q  <= '0;
               miss_q <= '0;
            end else if (ages) begin
               unique case (evt)
                  HL_DIAG: begin
                     age_q  <= '0;
                     miss_q <= miss_q + MISS_W'(1);
                     diag_q <= 1'b1;
                  end
                  HL_FAIL: begin
                     age_q  <= '0;
                     fail_q <= 1'b1;
                  end
                  default: age_q <= age_q + AGE_W'(1);
               endcase
            end
         end
      end

      assign diag_o[d]   = diag_q;
      assign failed_o[d] = fail_q;
   end

endmodule

// File: rtl/poll_sched.sv
module poll_sched
   import poll_pkg::*;
#(
   parameter int unsigned N_DEV     = 32,
   parameter int unsigned TBL_DEPTH = 64,
   parameter int unsigned MUX_W     = 8,
   parameter int unsigned AGE_SCANS = 16,
   parameter int unsigned MISS_MAX  = 3,
   parameter int unsigned IDLE_MUX  = 255,
   localparam int unsigned DEV_W    = $clog2(N_DEV),
   localparam int unsigned IDX_W    = $clog2(TBL_DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             slot_i,
   input  logic             frame_vld_i,
   input  logic [DEV_W-1:0] frame_dev_i,
   input  logic             ans_vld_i,
   input  logic [DEV_W-1:0] ans_dev_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [DEV_W-1:0] wr_dev_i,
   input  logic             wr_valid_i,
   output logic [MUX_W-1:0] mux_o,
   output logic [N_DEV-1:0] diag_o,
   output logic [N_DEV-1:0] failed_o
);

   localparam int unsigned AGE_W  = $clog2(AGE_SCANS);
   localparam int unsigned MISS_W = $clog2(MISS_MAX + 1);
   localparam logic [MUX_W-1:0] IDLE_CODE = MUX_W'(IDLE_MUX);

   if (!is_pow2(TBL_DEPTH)) begin : g_bad_depth
      $error("poll_sched: TBL_DEPTH must be a power of two");
   end
   if (!is_pow2(N_DEV) || N_DEV < 2) begin : g_bad_ndev
      $error("poll_sched: N_DEV must be a power of two of at least 2");
   end
   if (MUX_W <= DEV_W || IDLE_MUX < N_DEV || IDLE_MUX >= (1 << MUX_W)) begin : g_bad_idle
      $error("poll_sched: idle code must fit MUX_W and differ from every device");
   end
   if (AGE_SCANS < 2 || MISS_MAX < 1) begin : g_bad_limits
      $error("poll_sched: AGE_SCANS must be at least 2 and MISS_MAX at least 1");
   end

   logic [TBL_DEPTH-1:0]       tbl_vld;
   logic [TBL_DEPTH*DEV_W-1:0] tbl_dev;
   logic [N_DEV-1:0]           present;
   logic                       pick_found;
   logic [DEV_W-1:0]           pick_dev;
   logic [IDX_W-1:0]           pick_nxt;
   logic                       pick_wrap;
   logic [IDX_W-1:0]           ptr_q;
   logic                       scan_done;

   poll_table #(
      .TBL_DEPTH(TBL_DEPTH), .N_DEV(N_DEV), .DEV_W(DEV_W), .IDX_W(IDX_W)
   ) i_table (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_idx_i  (wr_idx_i),
      .wr_dev_i  (wr_dev_i),
      .wr_valid_i(wr_valid_i),
      .vld_o     (tbl_vld),
      .dev_o     (tbl_dev),
      .present_o (present)
   );

   poll_pick #(
      .TBL_DEPTH(TBL_DEPTH), .N_DEV(N_DEV), .DEV_W(DEV_W), .IDX_W(IDX_W)
   ) i_pick (
      .vld_i    (tbl_vld),
      .dev_i    (tbl_dev),
      .failed_i (failed_o),
      .ptr_i    (ptr_q),
      .found_o  (pick_found),
      .dev_o    (pick_dev),
      .nxt_ptr_o(pick_nxt),
      .wrap_o   (pick_wrap)
   );

   assign scan_done = slot_i && pick_wrap;

   poll_health #(
      .N_DEV(N_DEV), .DEV_W(DEV_W), .AGE_SCANS(AGE_SCANS),
      .MISS_MAX(MISS_MAX), .AGE_W(AGE_W), .MISS_W(MISS_W)
   ) i_health (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scan_i     (scan_done),
      .present_i  (present),
      .frame_vld_i(frame_vld_i),
      .frame_dev_i(frame_dev_i),
      .ans_vld_i  (ans_vld_i),
      .ans_dev_i  (ans_dev_i),
      .diag_o     (diag_o),
      .failed_o   (failed_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q <= '0;
         mux_o <= IDLE_CODE;
      end else if (slot_i) begin
         ptr_q <= pick_nxt;
         mux_o <= pick_found ? {{(MUX_W-DEV_W){1'b0}}, pick_dev} : IDLE_CODE;
      end
   end

endmodule

// File: rtl/poll_sched_chk.sv
module poll_sched_chk #(
   parameter int unsigned N_DEV    = 32,
   parameter int unsigned MUX_W    = 8,
   parameter int unsigned IDLE_MUX = 255,
   parameter int unsigned DEV_W    = 5
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             slot_i,
   input logic             frame_vld_i,
   input logic [DEV_W-1:0] frame_dev_i,
   input logic [MUX_W-1:0] mux_o,
   input logic [N_DEV-1:0] diag_o,
   input logic [N_DEV-1:0] failed_o
);

   // R2
   mux_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_i |=> $stable(mux_o));

   // R4
   mux_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mux_o == MUX_W'(IDLE_MUX)) || (mux_o < MUX_W'(N_DEV)));

   // R6
   diag_after_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (diag_o != '0) |-> $past(slot_i));

   // R9
   fail_rise_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((failed_o & ~$past(failed_o)) != '0) |-> $past(slot_i));

   // R10
   diag_not_failed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (diag_o & failed_o) == '0);

   // R7
   frame_clears_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_vld_i |=> (failed_o[$past(frame_dev_i)] == 1'b0));

endmodule

bind poll_sched poll_sched_chk #(
   .N_DEV(N_DEV), .MUX_W(MUX_W), .IDLE_MUX(IDLE_MUX), .DEV_W(DEV_W)
) i_poll_sched_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .slot_i     (slot_i),
   .frame_vld_i(frame_vld_i),
   .frame_dev_i(frame_dev_i),
   .mux_o      (mux_o),
   .diag_o     (diag_o),
   .failed_o   (failed_o)
);

// File: tb/test_poll_sched.sv
module test_poll_sched;

   localparam int CLK_PERIOD = 10;
   localparam int NDEV = 32;
   localparam int DEPTH = 64;
   localparam int AGE_LIM = 16;
   localparam int MISS_LIM = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slot = 1'b0;
   logic        frame_vld = 1'b0;
   logic [4:0]  frame_dev = '0;
   logic        ans_vld = 1'b0;
   logic [4:0]  ans_dev = '0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [4:0]  wr_dev = '0;
   logic        wr_valid = 1'b0;
   logic [7:0]  mux;
   logic [31:0] diag;
   logic [31:0] failed;

   int n_run = 0;
   int n_fail = 0;

   bit          tv   [DEPTH];
   int          td   [DEPTH];
   int          ptr = 0;
   int          age  [NDEV];
   int          miss [NDEV];
   bit          fl   [NDEV];
   int          exp_mux = 255;
   logic [31:0] exp_diag = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   poll_sched i_poll_sched (
      .clk_i(clk), .rst_ni(rst_n), .slot_i(slot),
      .frame_vld_i(frame_vld), .frame_dev_i(frame_dev),
      .ans_vld_i(ans_vld), .ans_dev_i(ans_dev),
      .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_dev_i(wr_dev), .wr_valid_i(wr_valid),
      .mux_o(mux), .diag_o(diag), .failed_o(failed)
   );

   function automatic logic [31:0] fl_vec();
      logic [31:0] v = '0;
      for (int d = 0; d < NDEV; d++) v[d] = fl[d];
      return v;
   endfunction

   task automatic chk(string tag, string what, longint got, longint exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   function automatic void model_slot();
      int idx = -1;
      bit wrap;
      bit pres [NDEV];
      for (int k = 0; k < DEPTH; k++) begin
         int c = (ptr + k) % DEPTH;
         if (idx < 0 && tv[c] && !fl[td[c]]) idx = c;
      end
      if (idx >= 0) begin
         int np = (idx + 1) % DEPTH;
         exp_mux = td[idx];
         wrap = (np <= ptr);
         ptr = np;
      end else begin
         exp_mux = 255;
         wrap = 1'b1;
      end
      for (int d = 0; d < NDEV; d++) pres[d] = 1'b0;
      for (int e = 0; e < DEPTH; e++) if (tv[e]) pres[td[e]] = 1'b1;
      exp_diag = '0;
      if (wrap) begin
         for (int d = 0; d < NDEV; d++) begin
            if (pres[d] && !fl[d]) begin
               if (age[d] == AGE_LIM - 1) begin
                  age[d] = 0;
                  if (miss[d] < MISS_LIM) begin
                     miss[d]++;
                     exp_diag[d] = 1'b1;
                  end else fl[d] = 1'b1;
               end else age[d]++;
            end
         end
      end
   endfunction

   task automatic do_slot(string tag, bit with_wr = 0, int wi = 0, int wd = 0, bit wv = 0);
      @(negedge clk);
      slot = 1'b1;
      if (with_wr) begin
         wr_en = 1'b1; wr_idx = 6'(wi); wr_dev = 5'(wd); wr_valid = wv;
      end
      model_slot();
      if (with_wr) begin
         tv[wi] = wv; td[wi] = wd;
      end
      @(negedge clk);
      slot = 1'b0;
      wr_en = 1'b0;
      chk(tag, "mux", mux, exp_mux);
      chk(tag, "diag", diag, exp_diag);
      chk(tag, "failed", failed, fl_vec());
   endtask

   task automatic do_write(int wi, int wd, bit wv);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 6'(wi); wr_dev = 5'(wd); wr_valid = wv;
      @(negedge clk);
      wr_en = 1'b0;
      tv[wi] = wv; td[wi] = wd;
   endtask

   task automatic do_frame(int d);
      @(negedge clk);
      frame_vld = 1'b1; frame_dev = 5'(d);
      @(negedge clk);
      frame_vld = 1'b0;
      age[d] = 0; miss[d] = 0; fl[d] = 1'b0;
   endtask

   task automatic do_ans(int d);
      @(negedge clk);
      ans_vld = 1'b1; ans_dev = 5'(d);
      @(negedge clk);
      ans_vld = 1'b0;
      age[d] = 0; miss[d] = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int e = 0; e < DEPTH; e++) begin tv[e] = 1'b0; td[e] = 0; end
      for (int d = 0; d < NDEV; d++) begin age[d] = 0; miss[d] = 0; fl[d] = 1'b0; end

      repeat (3) @(negedge clk);
      chk("R1", "mux in reset", mux, 8'hFF);
      chk("R1", "diag in reset", diag, 0);
      chk("R1", "failed in reset", failed, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "mux after reset", mux, 8'hFF);

      // empty table: idle code, no movement
      do_slot("R4");
      do_slot("R4");

      // dev 3 listed three times, 7 once, 9 once, one invalid entry
      do_write(0, 3, 1);
      do_write(1, 3, 1);
      do_write(2, 3, 1);
      do_write(10, 7, 1);
      do_write(40, 9, 1);
      do_write(20, 5, 0);
      for (int i = 0; i < 12; i++) do_slot("R2");

      // write in the same cycle as a slot, then later slots see it
      do_slot("R5", 1, 5, 12, 1);
      for (int i = 0; i < 6; i++) do_slot("R5");

      // remove dev 12 again; it must stop ageing
      do_write(5, 12, 0);

      // silent stretch: 3 kept alive, 7 answers, 9 unanswered until failed
      for (int i = 0; i < 420; i++) begin
         do_slot("R6");
         if (exp_diag[7]) do_ans(7);
         if (i % 20 == 19) do_frame(3);
      end
      chk("R9", "dev 9 failed", failed[9], 1);
      chk("R8", "dev 7 not failed", failed[7], 0);
      chk("R10", "dev 12 never flagged", failed[12], 0);
      for (int i = 0; i < 8; i++) do_slot("R3");

      // frame from the failed device restores it
      do_frame(9);
      chk("R7", "dev 9 cleared", failed[9], 0);
      for (int i = 0; i < 5; i++) do_slot("R7");

      // only dev 9 left: every slot is a pass; it fails, then idle
      do_write(0, 3, 0);
      do_write(1, 3, 0);
      do_write(2, 3, 0);
      do_write(10, 7, 0);
      for (int i = 0; i < 70; i++) do_slot("R9");
      chk("R9", "dev 9 failed again", failed[9], 1);
      for (int i = 0; i < 3; i++) do_slot("R4");
      chk("R10", "no diag to unlisted devices", diag, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule